// File: doc/BRIEF.md
# Paged Address Translator with Protection

This block turns a logical address into a physical address by searching a small associative table. Each table slot is tied to one physical page, and the slot's index is that page's number. A slot holds the logical page number that currently maps onto the page, a 2-bit protection level and an idle flag. On each access the block picks the matching slot, forms the physical address from the slot index and the page offset, and decides whether the access is allowed for its privilege tier.

Accesses are combinational. A request carries an address, a write flag, a privilege tier and a force-user override. The block returns the physical address, an abort flag and a forwarded memory request. Table slots are changed through a one-cycle programming port that writes at the clock edge. A runtime 2-bit field sets the page size, and with it the split between page number and offset.

Top module: `page_xlate`

## Requirements
- R1: After reset every slot is idle and matches no page. A user access to any address aborts, and a supervisor access passes through untranslated.
- R2: A supervisor access (priv 2'd2) without the override never aborts. On a hit, pa_o is the translated address. On a miss, pa_o equals the low PA_W bits of the address.
- R3: At level 0, user (priv 2'd0) and OS (priv 2'd1) may both read and write.
- R4: At level 1, OS may read and write. User may read, and a user write aborts.
- R5: At level 2, OS may only read, so an OS write aborts. Any user access aborts.
- R6: Level 3 gives exactly the permissions of level 2.
- R7: When acc_force_user_i is high, a supervisor or OS access is checked with user rights. Priv code 2'd3 is always treated as user.
- R8: A user or OS access whose page matches no active slot aborts.
- R9: page_size_i values 0, 1, 2 and 3 select 4, 8, 16 and 32 KB pages. The page number is addr >> (12+page_size_i). The physical address is (slot index << (12+page_size_i)) OR the offset.
- R10: mem_req_o equals acc_valid_i AND NOT abort_o. mem_we_o equals mem_req_o AND acc_we_i, so an aborted write is never forwarded.
- R11: A programming write replaces a slot's page number and level, or idles the slot, at the next clock edge. An access in the same cycle still sees the old contents.
- R12: When several slots match the same page, the lowest slot index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| page_size_i | input | 2 | Page size select: 4 KB << value |
| prog_en_i | input | 1 | Write one table slot |
| prog_idx_i | input | IDX_W | Slot (physical page) to write |
| prog_lpn_i | input | LPN_W | Logical page number for the slot |
| prog_lvl_i | input | 2 | Protection level for the slot |
| prog_idle_i | input | 1 | Mark the slot idle instead |
| acc_valid_i | input | 1 | Access present |
| acc_addr_i | input | VA_W | Logical address |
| acc_we_i | input | 1 | Access is a write |
| acc_priv_i | input | 2 | 0 user, 1 OS, 2 supervisor, 3 user |
| acc_force_user_i | input | 1 | Check the access with user rights |
| pa_o | output | PA_W | Physical address |
| abort_o | output | 1 | Access aborted |
| mem_req_o | output | 1 | Access forwarded to memory |
| mem_we_o | output | 1 | Forwarded access is a write |

## Verification
The bound checker checks on every cycle the rules that depend only on the tier, the hit flag and the hit level. These rules are: supervisor accesses never abort, a miss aborts for lower tiers, user access at levels 0, 1 and 2/3 behaves as the level requires, the override strips supervisor rights, and an abort blocks the forwarded request. The bench scenarios are the only way to show the rest. That covers address arithmetic across all four page sizes, the edge at which a programming write takes effect, idling a slot, and which of two matching slots wins.

// File: rtl/pxl_pkg.sv
package pxl_pkg;
  typedef enum logic [1:0] {
    PRIV_USER = 2'd0,
    PRIV_OS   = 2'd1,
    PRIV_SUP  = 2'd2,
    PRIV_RSVD = 2'd3
  } priv_e;

  localparam int unsigned OFF_MIN = 12;
endpackage

// File: rtl/pxl_entry.sv
module pxl_entry #(
  parameter int unsigned LPN_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             wr_idle_i,
  input  logic [LPN_W-1:0] wr_lpn_i,
  input  logic [1:0]       wr_lvl_i,
  input  logic [LPN_W-1:0] vpn_i,
  output logic             match_o,
  output logic [1:0]       lvl_o
);
  logic             live_q;
  logic [LPN_W-1:0] lpn_q;
  logic [1:0]       lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= 1'b0;
      lpn_q  <= '0;
      lvl_q  <= '0;
    end else if (wr_i) begin
      live_q <= !wr_idle_i;
      lpn_q  <= wr_lpn_i;
      lvl_q  <= wr_lvl_i;
    end
  end

  assign match_o = live_q && (lpn_q == vpn_i);
  assign lvl_o   = lvl_q;
endmodule

// File: rtl/pxl_pick.sv
module pxl_pick #(
  parameter int unsigned N     = 128,
  parameter int unsigned IDX_W = 7
) (
  input  logic             match_i [N],
  input  logic [1:0]       lvl_i   [N],
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [1:0]       lvl_o
);
  // lowest index wins: scan downward so the last assignment is the lowest
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    lvl_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_i[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
        lvl_o = lvl_i[i];
      end
    end
  end
endmodule

// File: rtl/pxl_perm.sv
module pxl_perm
  import pxl_pkg::*;
(
  input  logic [1:0] priv_i,
  input  logic       force_user_i,
  input  logic       we_i,
  input  logic       hit_i,
  input  logic [1:0] lvl_i,
  output logic       deny_o
);
  priv_e eff;

  always_comb begin
    if (force_user_i || priv_e'(priv_i) == PRIV_RSVD) eff = PRIV_USER;
    else                                              eff = priv_e'(priv_i);
  end

  always_comb begin
    deny_o = 1'b0;
    if (eff != PRIV_SUP) begin
      if (!hit_i) begin
        deny_o = 1'b1;
      end else begin
        unique case (lvl_i)
          2'd0:    deny_o = 1'b0;
          2'd1:    deny_o = (eff == PRIV_USER) && we_i;
          default: deny_o = (eff == PRIV_USER) || we_i;
        endcase
      end
    end
  end
endmodule

// File: rtl/page_xlate.sv
module page_xlate
  import pxl_pkg::*;
#(
  parameter int unsigned VA_W    = 25,
  parameter int unsigned N_PAGES = 128,
  localparam int unsigned IDX_W  = $clog2(N_PAGES),
  localparam int unsigned LPN_W  = VA_W - OFF_MIN,
  localparam int unsigned PA_W   = IDX_W + OFF_MIN + 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       page_size_i,
  input  logic             prog_en_i,
  input  logic [IDX_W-1:0] prog_idx_i,
  input  logic [LPN_W-1:0] prog_lpn_i,
  input  logic [1:0]       prog_lvl_i,
  input  logic             prog_idle_i,
  input  logic             acc_valid_i,
  input  logic [VA_W-1:0]  acc_addr_i,
  input  logic             acc_we_i,
  input  logic [1:0]       acc_priv_i,
  input  logic             acc_force_user_i,
  output logic [PA_W-1:0]  pa_o,
  output logic             abort_o,
  output logic             mem_req_o,
  output logic             mem_we_o
);
  logic [4:0]       sh;
  logic [LPN_W-1:0] vpn;
  logic             match [N_PAGES];
  logic [1:0]       lvl   [N_PAGES];
  logic             hit_any;
  logic [IDX_W-1:0] hit_idx;
  logic [1:0]       hit_lvl;
  logic             deny;
  logic [PA_W-1:0]  off_mask;
  logic [PA_W-1:0]  pa_xl;

  assign sh  = 5'(OFF_MIN) + {3'b000, page_size_i};
  assign vpn = LPN_W'(acc_addr_i >> sh);

  for (genvar g = 0; g < N_PAGES; g++) begin : g_slot
    pxl_entry #(.LPN_W(LPN_W)) u_ent (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (prog_en_i && (prog_idx_i == IDX_W'(g))),
      .wr_idle_i (prog_idle_i),
      .wr_lpn_i  (prog_lpn_i),
      .wr_lvl_i  (prog_lvl_i),
      .vpn_i     (vpn),
      .match_o   (match[g]),
      .lvl_o     (lvl[g])
    );
  end

  pxl_pick #(.N(N_PAGES), .IDX_W(IDX_W)) u_pick (
    .match_i (match),
    .lvl_i   (lvl),
    .hit_o   (hit_any),
    .idx_o   (hit_idx),
    .lvl_o   (hit_lvl)
  );

  pxl_perm u_perm (
    .priv_i       (acc_priv_i),
    .force_user_i (acc_force_user_i),
    .we_i         (acc_we_i),
    .hit_i        (hit_any),
    .lvl_i        (hit_lvl),
    .deny_o       (deny)
  );

  assign off_mask = (PA_W'(1) << sh) - PA_W'(1);
  assign pa_xl    = (PA_W'(hit_idx) << sh) | (PA_W'(acc_addr_i) & off_mask);
  assign pa_o     = hit_any ? pa_xl : acc_addr_i[PA_W-1:0];

  assign abort_o   = acc_valid_i && deny;
  assign mem_req_o = acc_valid_i && !deny;
  assign mem_we_o  = mem_req_o && acc_we_i;
endmodule

module page_xlate_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       acc_valid_i,
  input logic       acc_we_i,
  input logic [1:0] acc_priv_i,
  input logic       acc_force_user_i,
  input logic       abort_o,
  input logic       mem_req_o,
  input logic       mem_we_o,
  input logic       hit_any,
  input logic [1:0] hit_lvl
);
  logic as_user;
  logic as_os;
  assign as_user = acc_force_user_i || acc_priv_i == 2'd0 || acc_priv_i == 2'd3;
  assign as_os   = !acc_force_user_i && acc_priv_i == 2'd1;

  p_sup_free_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && acc_priv_i == 2'd2 && !acc_force_user_i |-> !abort_o);

  p_l0_open_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && (as_user || as_os) && hit_any && hit_lvl == 2'd0 |-> !abort_o);

  p_l1_user_wr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && as_user && hit_any && hit_lvl == 2'd1 |-> abort_o == acc_we_i);

  p_l2_user_none_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && as_user && hit_any && hit_lvl[1] |-> abort_o);

  p_l23_os_ro_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && as_os && hit_any && hit_lvl[1] |-> abort_o == acc_we_i);

  p_force_miss_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && acc_force_user_i && !hit_any |-> abort_o);

  p_miss_abort_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && (as_user || as_os) && !hit_any |-> abort_o);

  p_no_fwd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> !mem_req_o && !mem_we_o);

  p_fwd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && !abort_o |-> mem_req_o && (mem_we_o == acc_we_i));
endmodule

bind page_xlate page_xlate_chk u_chk (.*);

// File: tb/sim_page_xlate.sv
module sim_page_xlate;
  localparam int CLK_P = 10;
  localparam int VA_W = 25;
  localparam int IDX_W = 7;
  localparam int LPN_W = 13;
  localparam int PA_W = 22;

  typedef struct packed {
    logic [3:0] lpn;
    logic       we;
    logic [1:0] priv;
    logic       frc;
    logic       ab;
  } vec_t;

  // slots 5..8 hold pages 3..6 at levels 0..3
  localparam vec_t VECS [22] = '{
    '{4'd3, 1'b1, 2'd0, 1'b0, 1'b0}, '{4'd3, 1'b0, 2'd0, 1'b0, 1'b0},
    '{4'd3, 1'b1, 2'd1, 1'b0, 1'b0},
    '{4'd4, 1'b0, 2'd0, 1'b0, 1'b0}, '{4'd4, 1'b1, 2'd0, 1'b0, 1'b1},
    '{4'd4, 1'b1, 2'd1, 1'b0, 1'b0}, '{4'd4, 1'b0, 2'd1, 1'b0, 1'b0},
    '{4'd5, 1'b0, 2'd0, 1'b0, 1'b1}, '{4'd5, 1'b1, 2'd0, 1'b0, 1'b1},
    '{4'd5, 1'b0, 2'd1, 1'b0, 1'b0}, '{4'd5, 1'b1, 2'd1, 1'b0, 1'b1},
    '{4'd5, 1'b1, 2'd2, 1'b0, 1'b0},
    '{4'd6, 1'b0, 2'd0, 1'b0, 1'b1}, '{4'd6, 1'b0, 2'd1, 1'b0, 1'b0},
    '{4'd6, 1'b1, 2'd1, 1'b0, 1'b1}, '{4'd6, 1'b1, 2'd2, 1'b0, 1'b0},
    '{4'd4, 1'b1, 2'd2, 1'b1, 1'b1}, '{4'd4, 1'b0, 2'd2, 1'b1, 1'b0},
    '{4'd5, 1'b0, 2'd1, 1'b1, 1'b1}, '{4'd3, 1'b1, 2'd2, 1'b1, 1'b0},
    '{4'd3, 1'b1, 2'd3, 1'b0, 1'b0}, '{4'd4, 1'b1, 2'd3, 1'b0, 1'b1}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       page_size = '0;
  logic             prog_en = 1'b0;
  logic [IDX_W-1:0] prog_idx = '0;
  logic [LPN_W-1:0] prog_lpn = '0;
  logic [1:0]       prog_lvl = '0;
  logic             prog_idle = 1'b0;
  logic             acc_valid = 1'b0;
  logic [VA_W-1:0]  acc_addr = '0;
  logic             acc_we = 1'b0;
  logic [1:0]       acc_priv = '0;
  logic             acc_frc = 1'b0;
  logic [PA_W-1:0]  pa;
  logic             abort_w, mreq, mwe;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  page_xlate u0 (
    .clk_i(clk), .rst_ni(rst_n), .page_size_i(page_size),
    .prog_en_i(prog_en), .prog_idx_i(prog_idx), .prog_lpn_i(prog_lpn),
    .prog_lvl_i(prog_lvl), .prog_idle_i(prog_idle),
    .acc_valid_i(acc_valid), .acc_addr_i(acc_addr), .acc_we_i(acc_we),
    .acc_priv_i(acc_priv), .acc_force_user_i(acc_frc),
    .pa_o(pa), .abort_o(abort_w), .mem_req_o(mreq), .mem_we_o(mwe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic prog(input int idx, input int lpn, input int lvl, input bit idle);
    @(negedge clk);
    prog_en = 1'b1; prog_idx = IDX_W'(idx); prog_lpn = LPN_W'(lpn);
    prog_lvl = 2'(lvl); prog_idle = idle;
    @(negedge clk);
    prog_en = 1'b0; prog_idle = 1'b0;
  endtask

  task automatic access(input logic [VA_W-1:0] a, input bit we, input int pr, input bit frc);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_we = we; acc_priv = 2'(pr); acc_frc = frc;
    #2;
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: idle after reset
    access(25'((3 << 12) | 'h24), 1'b0, 0, 1'b0);
    chk("R1 user abort after reset", 32'(abort_w), 1);
    access(25'h012345, 1'b0, 2, 1'b0);
    chk("R1 sup no abort after reset", 32'(abort_w), 0);
    chk("R1 sup pass-through pa", 32'(pa), 32'h012345);

    for (int k = 0; k < 4; k++) prog(5 + k, 3 + k, k, 1'b0);

    for (int i = 0; i < 22; i++) begin
      automatic vec_t v = VECS[i];
      automatic string tag;
      if (v.frc || v.priv == 2'd3) tag = "R7";
      else case (v.lpn)
        4'd3: tag = "R3";
        4'd4: tag = "R4";
        4'd5: tag = v.priv == 2'd2 ? "R2" : "R5";
        default: tag = v.priv == 2'd2 ? "R2" : "R6";
      endcase
      access(25'((int'(v.lpn) << 12) | 'h24), v.we, int'(v.priv), v.frc);
      chk($sformatf("%s abort vec %0d", tag, i), 32'(abort_w), 32'(v.ab));
      if (v.ab) chk($sformatf("R10 req blocked vec %0d", i), 32'({mreq, mwe}), 0);
      else begin
        chk($sformatf("%s pa vec %0d", tag, i), 32'(pa), ((int'(v.lpn) + 2) << 12) | 'h24);
        chk($sformatf("R10 req vec %0d", i), 32'({mreq, mwe}), 32'({1'b1, v.we}));
      end
    end

    // R8 / R2: miss
    access(25'((9 << 12) | 'h10), 1'b0, 0, 1'b0);
    chk("R8 user miss", 32'(abort_w), 1);
    access(25'((9 << 12) | 'h10), 1'b0, 1, 1'b0);
    chk("R8 os miss", 32'(abort_w), 1);
    access(25'((9 << 12) | 'h10), 1'b1, 2, 1'b0);
    chk("R2 sup miss abort", 32'(abort_w), 0);
    chk("R2 sup miss pa", 32'(pa), (9 << 12) | 'h10);

    // R9: page sizes
    for (int ps = 1; ps < 4; ps++) begin
      automatic int off = (1 << (12 + ps)) - 4;
      @(negedge clk); page_size = 2'(ps);
      access(25'((3 << (12 + ps)) | off), 1'b0, 0, 1'b0);
      chk($sformatf("R9 abort ps %0d", ps), 32'(abort_w), 0);
      chk($sformatf("R9 pa ps %0d", ps), 32'(pa), (5 << (12 + ps)) | off);
    end
    @(negedge clk); page_size = 2'd0;

    // R12: lower slot wins
    prog(2, 4, 0, 1'b0);
    access(25'((4 << 12) | 'h24), 1'b1, 0, 1'b0);
    chk("R12 abort", 32'(abort_w), 0);
    chk("R12 pa", 32'(pa), (2 << 12) | 'h24);

    // R11: write lands at edge
    @(negedge clk);
    prog_en = 1'b1; prog_idx = 7'd5; prog_lpn = 13'd3; prog_lvl = 2'd2;
    acc_valid = 1'b1; acc_addr = 25'((3 << 12) | 'h24); acc_we = 1'b1;
    acc_priv = 2'd0; acc_frc = 1'b0;
    #2 chk("R11 old contents same cycle", 32'(abort_w), 0);
    @(posedge clk); #2;
    chk("R11 new level after edge", 32'(abort_w), 1);
    @(negedge clk); prog_en = 1'b0;
    prog(5, 3, 0, 1'b1);
    access(25'((3 << 12) | 'h24), 1'b0, 1, 1'b0);
    chk("R11 idled slot os miss", 32'(abort_w), 1);
    access(25'((3 << 12) | 'h24), 1'b0, 2, 1'b0);
    chk("R11 idled slot sup pass", 32'(pa), (3 << 12) | 'h24);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule